// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block measures how long a capture input stays high, counted in timer clock cycles. The input passes through a synchronizer and an edge detector. A rising edge reloads an up-counter so that counting begins at that edge. A qualifying edge copies the running count into a capture register and raises a one-cycle event strobe. The edge-select field chooses the qualifying edges. With falling edges selected, the captured value is the high time of the pulse. With rising edges selected, it is the period between successive pulses.

Software starts the counter in one of two ways. A start pulse begins counting at once. An arm pulse makes the block wait for the first rising edge of the input. In repeat mode the block keeps measuring pulse after pulse. In one-shot mode it stops after the first capture. A programmable limit value caps the counter. Reaching the limit sets a sticky overflow flag, which software clears with a clear pulse.

Top module: `pwc_timer`

## Requirements
- R1: After reset, `cap_val`, `count`, `cap_evt`, `ovf` and `running` are all 0.
- R2: A `start` pulse sets `running` and zeroes `count` at the next clock edge. `count` then rises by one on every later edge while running.
- R3: With `edge_sel` = 2'b10 (falling edge only) and `load_val` large enough, a high pulse lasting W clock cycles gives `cap_val` = W. This holds because the rising edge reloads the counter with 1.
- R4: Each capture drives `cap_evt` high for exactly one cycle. `cap_val` changes only in a cycle in which `cap_evt` is high.
- R5: `edge_sel` encoding: bit 0 selects rising-edge capture and bit 1 selects falling-edge capture. 2'b01 captures the period from one rising edge to the next. 2'b11 captures on both edges. 2'b00 never captures.
- R6: In repeat mode (`repeat_mode` = 1), successive pulses are each captured with their own width.
- R7: In one-shot mode (`repeat_mode` = 0), `running` clears at the first capture. Later input pulses produce no capture and leave `cap_val` unchanged until a new `start` or `arm` pulse.
- R8: After an `arm` pulse, `running` stays 0 and `count` stays 0 until the first rising input edge. That edge starts counting, and a following falling edge captures the pulse width W.
- R9: While running, `count` saturates at `load_val` and sets `ovf`. A pulse longer than `load_val` captures `load_val`.
- R10: `ovf` is sticky and clears on an `ovf_clr` pulse. If an overflow condition is present in the same cycle as the clear, the set wins and `ovf` stays 1.
- R11: While neither running nor armed, input edges change neither `count` nor `cap_val`, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse: zero the counter and begin counting |
| arm | input | 1 | One-cycle pulse: zero the counter and wait for the first rising input edge |
| repeat_mode | input | 1 | 1 = keep measuring, 0 = stop after one capture |
| edge_sel | input | 2 | Capture edges: bit 0 rising, bit 1 falling |
| load_val | input | CNT_W | Counter limit (saturation value) |
| ovf_clr | input | 1 | One-cycle pulse clearing the overflow flag |
| cap_in | input | 1 | Asynchronous signal being measured |
| cap_val | output | CNT_W | Last captured count |
| cap_evt | output | 1 | One-cycle capture strobe |
| count | output | CNT_W | Live counter value |
| ovf | output | 1 | Sticky overflow flag |
| running | output | 1 | Counter is active |

## Verification
Two functions can fall in the same cycle: the overflow set caused by a saturated counter, and the software clear of that flag. The collision is provoked by holding the input high well beyond `load_val`, so the counter sits at its limit. The clear pulse is then issued while the input is still high. The flag is expected to stay set, because saturation reasserts it in that very cycle. Once the pulse ends and the counter is no longer running, a second clear is expected to drop the flag. The capture of the saturated value on the falling edge is judged in the same run.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  // Decide whether the detected edges qualify for a capture.
  function automatic logic capture_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

endpackage

// File: rtl/pwc_sync_edge.sv
module pwc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise = sync_q[LAST] & ~prev_q;
  assign fall = ~sync_q[LAST] & prev_q;
endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic arm,
  input  logic repeat_mode,
  input  logic rise,
  input  logic hit,
  output logic running,
  output logic armed,
  output logic load_now,
  output logic clear_now
);
  logic run_d, arm_d;

  assign clear_now = start | arm;
  assign load_now  = rise & (running | armed) & ~clear_now;

  always_comb begin
    run_d = running;
    arm_d = armed;
    if (start) begin
      run_d = 1'b1;
      arm_d = 1'b0;
    end else if (arm) begin
      run_d = 1'b0;
      arm_d = 1'b1;
    end else begin
      if (armed && rise) begin
        run_d = 1'b1;
        arm_d = 1'b0;
      end
      if (running && hit && !repeat_mode) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      armed   <= 1'b0;
    end else begin
      running <= run_d;
      armed   <= arm_d;
    end
  end
endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_now,
  input  logic             load_now,
  input  logic             running,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             sat
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // The edge cycle itself counts, unless the limit is zero.
  function automatic logic [CNT_W-1:0] first_val(input logic [CNT_W-1:0] lim);
    return (lim == '0) ? '0 : ONE;
  endfunction

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] lim);
    return (cur >= lim) ? cur : cur + ONE;
  endfunction

  logic [CNT_W-1:0] count_d;
  logic             ovf_set;

  assign sat     = running & ~load_now & ~clear_now & (count >= load_val);
  assign ovf_set = sat;

  always_comb begin
    count_d = count;
    if (clear_now)    count_d = '0;
    else if (load_now) count_d = first_val(load_val);
    else if (running)  count_d = step(count, load_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      count <= count_d;
      ovf   <= ovf_set | (ovf & ~ovf_clr);
    end
  end
endmodule

// File: rtl/pwc_capture.sv
module pwc_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             rise,
  input  logic             fall,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] count,
  output logic             hit,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt
);
  import pwc_pkg::*;

  assign hit = running & capture_hit(edge_sel, rise, fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val <= '0;
      cap_evt <= 1'b0;
    end else begin
      cap_evt <= hit;
      if (hit) cap_val <= count;
    end
  end
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             arm,
  input  logic             repeat_mode,
  input  logic [1:0]       edge_sel,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ovf_clr,
  input  logic             cap_in,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             running
);
  // Named internal events, observed by the bound checker.
  logic rise_w, fall_w, hit_w, armed_w, load_w, clear_w, sat_w;

  pwc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise_w), .fall(fall_w)
  );

  pwc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .arm(arm),
    .repeat_mode(repeat_mode), .rise(rise_w), .hit(hit_w),
    .running(running), .armed(armed_w), .load_now(load_w), .clear_now(clear_w)
  );

  pwc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_now(clear_w), .load_now(load_w),
    .running(running), .load_val(load_val), .ovf_clr(ovf_clr),
    .count(count), .ovf(ovf), .sat(sat_w)
  );

  pwc_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .running(running), .rise(rise_w), .fall(fall_w),
    .edge_sel(edge_sel), .count(count), .hit(hit_w),
    .cap_val(cap_val), .cap_evt(cap_evt)
  );
endmodule

// File: rtl/pwc_timer_checker.sv
module pwc_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             repeat_mode,
  input logic [CNT_W-1:0] load_val,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_evt,
  input logic [CNT_W-1:0] count,
  input logic             ovf,
  input logic             running,
  input logic             rise_w,
  input logic             fall_w,
  input logic             hit_w,
  input logic             armed_w,
  input logic             load_w,
  input logic             clear_w
);
  assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_w && fall_w));

  assert_hit_gives_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_w |=> cap_evt);

  assert_cap_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |-> $stable(cap_val));

  assert_one_shot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && !repeat_mode && !clear_w) |=> !running);

  assert_sat_sets_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !load_w && !clear_w && count >= load_val) |=> ovf);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !clear_w && !(armed_w && rise_w)) |=> $stable(count));

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && count == '0));
endmodule

bind pwc_timer pwc_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .repeat_mode(repeat_mode),
  .load_val(load_val), .ovf_clr(ovf_clr), .cap_val(cap_val), .cap_evt(cap_evt),
  .count(count), .ovf(ovf), .running(running), .rise_w(rise_w), .fall_w(fall_w),
  .hit_w(hit_w), .armed_w(armed_w), .load_w(load_w), .clear_w(clear_w)
);

// File: tb/pwc_timer_bench.sv
module pwc_timer_bench;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0, arm = 1'b0, repeat_mode = 1'b1, ovf_clr = 1'b0, cap_in = 1'b0;
  logic [1:0]       edge_sel = 2'b10;
  logic [CNT_W-1:0] load_val = 16'd1000;
  logic [CNT_W-1:0] cap_val, count;
  logic             cap_evt, ovf, running;

  int checks = 0, fails = 0;
  int evt_n = 0;
  int caps[0:63];
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwc_timer #(.CNT_W(CNT_W)) u_pwc_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .arm(arm), .repeat_mode(repeat_mode),
    .edge_sel(edge_sel), .load_val(load_val), .ovf_clr(ovf_clr), .cap_in(cap_in),
    .cap_val(cap_val), .cap_evt(cap_evt), .count(count), .ovf(ovf), .running(running)
  );

  // Event monitor, sampled between edges.
  always @(negedge clk) begin
    if (rst_n && cap_evt) begin
      if (evt_n < 64) caps[evt_n] = int'(cap_val);
      evt_n = evt_n + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 0; arm = 0; ovf_clr = 0; cap_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_sw(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic pulse_in(input int hi, input int lo);
    cap_in = 1'b1;
    repeat (hi) @(negedge clk);
    cap_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cap_val", int'(cap_val), 0);
    chk("R1 count", int'(count), 0);
    chk("R1 cap_evt", int'(cap_evt), 0);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 running", int'(running), 0);
  endtask

  task automatic t_idle_and_start();
    int base;
    do_reset();
    edge_sel = 2'b11;
    base = evt_n;
    pulse_in(4, 8);
    chk("R11 no event while idle", evt_n - base, 0);
    chk("R11 count held while idle", int'(count), 0);
    pulse_sw(start);
    chk("R2 running after start", int'(running), 1);
    chk("R2 count zero after start", int'(count), 0);
    repeat (5) @(negedge clk);
    chk("R2 count after five cycles", int'(count), 5);
  endtask

  task automatic t_width_repeat();
    int base;
    do_reset();
    edge_sel = 2'b10; repeat_mode = 1; load_val = 16'd1000;
    pulse_sw(start);
    base = evt_n;
    pulse_in(7, 8);
    chk("R3 one event", evt_n - base, 1);
    chk("R3 width 7", caps[base], 7);
    repeat (6) @(negedge clk);
    chk("R4 single-cycle strobe and hold", evt_n - base, 1);
    chk("R4 cap_val held", int'(cap_val), 7);
    pulse_in(4, 8);
    pulse_in(11, 8);
    chk("R6 two more events", evt_n - base, 3);
    chk("R6 second width", caps[base+1], 4);
    chk("R6 third width", caps[base+2], 11);
    chk("R6 still running", int'(running), 1);
  endtask

  task automatic t_one_shot();
    int base;
    do_reset();
    edge_sel = 2'b10; repeat_mode = 0; load_val = 16'd1000;
    pulse_sw(start);
    base = evt_n;
    pulse_in(5, 8);
    chk("R7 captured width", caps[base], 5);
    chk("R7 running cleared", int'(running), 0);
    pulse_in(3, 8);
    chk("R7 no further event", evt_n - base, 1);
    chk("R7 cap_val unchanged", int'(cap_val), 5);
    repeat_mode = 1;
  endtask

  task automatic t_arm();
    int base;
    do_reset();
    edge_sel = 2'b10; repeat_mode = 1; load_val = 16'd1000;
    pulse_sw(arm);
    repeat (4) @(negedge clk);
    chk("R8 not running while armed", int'(running), 0);
    chk("R8 count still zero", int'(count), 0);
    base = evt_n;
    pulse_in(6, 8);
    chk("R8 event after armed start", evt_n - base, 1);
    chk("R8 width 6", caps[base], 6);
    chk("R8 running after edge", int'(running), 1);
  endtask

  task automatic t_edges();
    int base;
    do_reset();
    repeat_mode = 1; load_val = 16'd1000;
    edge_sel = 2'b01;
    pulse_sw(start);
    base = evt_n;
    pulse_in(4, 6);
    pulse_in(4, 6);
    chk("R5 rising: two events", evt_n - base, 2);
    chk("R5 rising: period 10", caps[base+1], 10);
    edge_sel = 2'b11;
    base = evt_n;
    pulse_in(3, 5);
    pulse_in(3, 5);
    chk("R5 both: four events", evt_n - base, 4);
    chk("R5 both: first fall width", caps[base+1], 3);
    chk("R5 both: period 8", caps[base+2], 8);
    chk("R5 both: second fall width", caps[base+3], 3);
    edge_sel = 2'b00;
    base = evt_n;
    pulse_in(3, 5);
    chk("R5 none: no event", evt_n - base, 0);
  endtask

  task automatic t_overflow();
    int base;
    do_reset();
    edge_sel = 2'b10; repeat_mode = 0; load_val = 16'd10;
    pulse_sw(start);
    base = evt_n;
    cap_in = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 count saturated", int'(count), 10);
    chk("R9 ovf set", int'(ovf), 1);
    pulse_sw(ovf_clr);
    chk("R10 set wins over clear", int'(ovf), 1);
    cap_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 captured limit", caps[base], 10);
    pulse_sw(ovf_clr);
    chk("R10 clear after idle", int'(ovf), 0);
    repeat_mode = 1; load_val = 16'd1000;
  endtask

  initial begin
    t_reset();
    t_idle_and_start();
    t_width_repeat();
    t_one_shot();
    t_arm();
    t_edges();
    t_overflow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule